// File: doc/BRIEF.md
# Load/Store Bus Cycle Sequencer

This block is the memory-facing end of a small pipelined processor core. It takes one decoded data-transfer request at a time (a single-word load, a single-word store, or a block transfer of several registers in either direction) and turns it into the fixed stream of bus cycles that the instruction needs. Each emitted cycle carries a cycle type (sequential or non-sequential), an address and a direction. Each cycle after the data words refetches the instruction stream from a supplied fetch address.

The bus is address-pipelined. An address is driven in one cycle, and the matching data moves in the following cycle while the next address is already on the bus. The block therefore gives a data-phase strobe one cycle after each address-phase cycle. It also gives a look-ahead flag that warns the memory controller one cycle early that the next bus cycle will be non-sequential, so the controller can leave page mode in time.

Requests use a valid/ready handshake. The requester holds `req_valid` and all request fields steady until a cycle in which `req_ready` is also high; the transfer is taken at that clock edge. `req_ready` is high only while no cycle pattern is in progress, so a request that arrives while the block is busy waits. The bus side has no back-pressure: once a request is taken, its pattern runs at one bus cycle per clock.

Top module: `seq_bus_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, and `bus_valid`, `nseq_next` and `data_valid` are 0.
- R2: With `req_multi`=0 and `req_write`=0 (single load), the block emits exactly three cycles: non-sequential read at `req_addr`, non-sequential read at `req_fetch`, then sequential read at `req_fetch`+4. `req_count` has no effect.
- R3: With `req_multi`=0 and `req_write`=1 (single store), the block emits exactly two cycles: non-sequential write at `req_addr`, then non-sequential read at `req_fetch`.
- R4: With `req_multi`=1 and a count of n words, the first word is a non-sequential cycle at `req_addr`. It is followed by n-1 sequential cycles in the same direction. After that come the same refetch cycles as in R2 (load) or R3 (store). A count of one gives the same pattern as the single transfer.
- R5: Within a block transfer, each word address is 4 above the previous one when `req_descend`=0 and 4 below it when `req_descend`=1. Addresses wrap modulo 2^AW.
- R6: A block transfer with `req_count`=0 is treated as a count of one.
- R7: `nseq_next` is 1 in a cycle exactly when the next cycle holds a non-sequential bus cycle. This is the case in the accept cycle and in the last data-word cycle, and in no other cycle.
- R8: `data_valid` and `data_write` repeat `bus_valid` and `bus_write` one cycle later.
- R9: `req_ready` is 0 from the accept edge until the clock after the last bus cycle. A request held valid while `req_ready` is 0 is not taken, and its changing fields do not alter the running pattern.
- R10: Encodings: `bus_seq`=1 means sequential and 0 means non-sequential; `bus_write`=1 means write and 0 means read; `bus_seq` and `bus_write` are meaningful only while `bus_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_multi | input | 1 | 1 = block transfer using req_count |
| req_descend | input | 1 | 1 = block addresses step downward |
| req_count | input | CW | Word count of a block transfer |
| req_addr | input | AW | First data word address |
| req_fetch | input | AW | Instruction address to refetch after the data |
| bus_valid | output | 1 | Address-phase cycle present |
| bus_seq | output | 1 | 1 = sequential cycle, 0 = non-sequential |
| bus_write | output | 1 | Direction of the cycle |
| bus_addr | output | AW | Address of the cycle |
| nseq_next | output | 1 | Next cycle will be non-sequential |
| data_valid | output | 1 | Data phase of the previous address cycle |
| data_write | output | 1 | Direction of that data phase |

## Verification
Two functions can fall in the same cycle. The first is the opening non-sequential word. The second is the look-ahead warning for the refetch that follows the last word. In a single transfer, or a block of count one or zero, both happen in one cycle. The bench drives those cases and compares every cycle's type, address, direction and warning with a pattern computed from the request. It also holds a changing request valid through a busy run and judges that the pattern is unchanged, that nothing is accepted, and that `req_ready` comes back exactly one cycle after the last bus cycle.

// File: rtl/seqbus_pkg.sv
package seqbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_XFER    = 2'd1,
    PH_FETCH_N = 2'd2,
    PH_FETCH_S = 2'd3
  } phase_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/seq_ctl.sv
module seq_ctl
  import seqbus_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          req_write,
  input  logic          req_multi,
  input  logic [CW-1:0] req_count,
  output phase_e        phase,
  output logic          first,
  output logic          last_word,
  output logic          wr
);
  localparam logic [CW-1:0] ONE = CW'(1);

  phase_e        phase_q;
  logic [CW-1:0] left_q;
  logic          first_q;
  logic          wr_q;
  logic [CW-1:0] start_cnt;

  // count of zero, or a single transfer, both run one word
  always_comb begin
    if (!req_multi || req_count == '0) start_cnt = ONE;
    else                               start_cnt = req_count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      left_q  <= '0;
      first_q <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (fire) begin
            phase_q <= PH_XFER;
            left_q  <= start_cnt;
            first_q <= 1'b1;
            wr_q    <= req_write;
          end
        end
        PH_XFER: begin
          first_q <= 1'b0;
          if (left_q == ONE) phase_q <= PH_FETCH_N;
          else               left_q  <= left_q - ONE;
        end
        PH_FETCH_N: phase_q <= wr_q ? PH_IDLE : PH_FETCH_S;
        PH_FETCH_S: phase_q <= PH_IDLE;
        default:    phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign first     = first_q;
  assign last_word = (phase_q == PH_XFER) && (left_q == ONE);
  assign wr        = wr_q;
endmodule

// File: rtl/seq_addr.sv
module seq_addr
  import seqbus_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          req_descend,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_fetch,
  input  phase_e        phase,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] data_q;
  logic [AW-1:0] fetch_q;
  logic          desc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      fetch_q <= '0;
      desc_q  <= 1'b0;
    end else if (fire) begin
      data_q  <= req_addr;
      fetch_q <= req_fetch;
      desc_q  <= req_descend;
    end else if (phase == PH_XFER) begin
      data_q  <= desc_q ? (data_q - STEP) : (data_q + STEP);
    end
  end

  always_comb begin
    unique case (phase)
      PH_XFER:    addr = data_q;
      PH_FETCH_N: addr = fetch_q;
      PH_FETCH_S: addr = fetch_q + STEP;
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/seq_dphase.sv
module seq_dphase #(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_valid,
  input  logic a_write,
  output logic d_valid,
  output logic d_write
);
  logic [LAT:0] v_pipe;
  logic [LAT:0] w_pipe;

  assign v_pipe[0] = a_valid;
  assign w_pipe[0] = a_write;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_pipe[s+1] <= 1'b0;
        w_pipe[s+1] <= 1'b0;
      end else begin
        v_pipe[s+1] <= v_pipe[s];
        w_pipe[s+1] <= v_pipe[s] & w_pipe[s];
      end
    end
  end

  assign d_valid = v_pipe[LAT];
  assign d_write = w_pipe[LAT];
endmodule

// File: rtl/seq_bus_sequencer.sv
module seq_bus_sequencer
  import seqbus_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_multi,
  input  logic          req_descend,
  input  logic [CW-1:0] req_count,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_fetch,
  output logic          bus_valid,
  output logic          bus_seq,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          nseq_next,
  output logic          data_valid,
  output logic          data_write
);
  phase_e phase;
  logic   first;
  logic   last_word;
  logic   wr;
  logic   fire;

  assign req_ready = (phase == PH_IDLE);
  assign fire      = req_valid && req_ready;

  seq_ctl #(.CW(CW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .req_write (req_write),
    .req_multi (req_multi),
    .req_count (req_count),
    .phase     (phase),
    .first     (first),
    .last_word (last_word),
    .wr        (wr)
  );

  seq_addr #(.AW(AW)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .req_descend (req_descend),
    .req_addr    (req_addr),
    .req_fetch   (req_fetch),
    .phase       (phase),
    .addr        (bus_addr)
  );

  assign bus_valid = (phase != PH_IDLE);
  assign bus_seq   = ((phase == PH_XFER) && !first) || (phase == PH_FETCH_S);
  assign bus_write = (phase == PH_XFER) && wr;
  // next cycle is non-sequential: first data word, or the refetch after the last word
  assign nseq_next = fire || last_word;

  seq_dphase #(.LAT(1)) u_dph (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_valid (bus_valid),
    .a_write (bus_write),
    .d_valid (data_valid),
    .d_write (data_write)
  );
endmodule

// File: rtl/seqbus_chk.sv
module seqbus_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_seq,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          nseq_next,
  input logic          data_valid,
  input logic          data_write
);
  localparam logic [AW-1:0] WSTEP = AW'(4);

  AST_ACCEPT_OPENS_N: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_valid && !bus_seq)); // R4
  AST_WARN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    nseq_next |=> (bus_valid && !bus_seq)); // R7
  AST_N_WAS_WARNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_seq) |-> $past(nseq_next)); // R7
  AST_SEQ_HAS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_seq) |-> $past(bus_valid)); // R4
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_seq) |->
      (bus_addr == $past(bus_addr) + WSTEP || bus_addr == $past(bus_addr) - WSTEP)); // R5
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> (data_valid && data_write == $past(bus_write))); // R8
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !data_valid); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready); // R9
endmodule

bind seq_bus_sequencer seqbus_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .bus_valid  (bus_valid),
  .bus_seq    (bus_seq),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .nseq_next  (nseq_next),
  .data_valid (data_valid),
  .data_write (data_write)
);

// File: tb/seq_bus_sequencer_tb.sv
module seq_bus_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 5;
  localparam int MAXL = 40;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_multi = 1'b0;
  logic          req_descend = 1'b0;
  logic [CW-1:0] req_count = '0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] req_fetch = '0;
  logic          bus_valid, bus_seq, bus_write, nseq_next, data_valid, data_write;
  logic [AW-1:0] bus_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic          e_seq  [MAXL];
  logic          e_wr   [MAXL];
  logic [AW-1:0] e_addr [MAXL];
  int            e_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_bus_sequencer #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_multi(req_multi), .req_descend(req_descend),
    .req_count(req_count), .req_addr(req_addr), .req_fetch(req_fetch),
    .bus_valid(bus_valid), .bus_seq(bus_seq), .bus_write(bus_write),
    .bus_addr(bus_addr), .nseq_next(nseq_next), .data_valid(data_valid),
    .data_write(data_write)
  );

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // builds the expected cycle list from the request (R2, R3, R4, R5, R6)
  task automatic build(input logic wr, input logic multi, input logic desc,
                       input logic [CW-1:0] cnt, input logic [AW-1:0] a,
                       input logic [AW-1:0] f);
    int n;
    n = (!multi || cnt == 0) ? 1 : int'(cnt);
    e_len = 0;
    for (int i = 0; i < n; i++) begin
      e_seq[e_len]  = (i != 0);
      e_wr[e_len]   = wr;
      e_addr[e_len] = desc ? a - AW'(4*i) : a + AW'(4*i);
      e_len++;
    end
    e_seq[e_len] = 1'b0; e_wr[e_len] = 1'b0; e_addr[e_len] = f; e_len++;
    if (!wr) begin
      e_seq[e_len] = 1'b1; e_wr[e_len] = 1'b0; e_addr[e_len] = f + 32'd4; e_len++;
    end
  endtask

  // runs one request and checks every cycle; junk keeps a changing request valid while busy (R9)
  task automatic run(input string req, input logic wr, input logic multi,
                     input logic desc, input logic [CW-1:0] cnt,
                     input logic [AW-1:0] a, input logic [AW-1:0] f, input bit junk);
    build(wr, multi, desc, cnt, a, f);
    @(negedge clk);
    check("R9", "ready before accept", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_multi = multi; req_descend = desc;
    req_count = cnt; req_addr = a; req_fetch = f;
    #1;
    check("R7", "warning in accept cycle", nseq_next, 1);
    @(negedge clk);
    if (junk) begin
      req_write = ~wr; req_multi = 1'b1; req_descend = ~desc; req_count = 5'd9;
      req_addr = 32'hDEAD_0000; req_fetch = 32'hBEEF_0000;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 0; k < e_len; k++) begin
      #1;
      check(req, "bus_valid", bus_valid, 1);
      check(req, "bus_seq", bus_seq, e_seq[k]);
      check(req, "bus_addr", bus_addr, e_addr[k]);
      check(req, "bus_write", bus_write, e_wr[k]);
      check("R7", "nseq_next", nseq_next, (k + 1 < e_len) ? !e_seq[k+1] : 1'b0);
      check("R9", "ready while busy", req_ready, 0);
      if (k > 0) begin
        check("R8", "data_valid", data_valid, 1);
        check("R8", "data_write", data_write, e_wr[k-1]);
      end
      if (junk) req_addr = req_addr + 32'h10;
      if (k == e_len - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    #1;
    check("R9", "ready after last cycle", req_ready, 1);
    check(req, "bus idle after pattern", bus_valid, 0);
    check("R8", "last data phase", data_valid, 1);
    check("R8", "last data direction", data_write, e_wr[e_len-1]);
    @(negedge clk);
    #1;
    check("R8", "data phase ends", data_valid, 0);
    check("R9", "nothing accepted", bus_valid, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R1", "ready in reset", req_ready, 1);
    check("R1", "bus_valid in reset", bus_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "ready", req_ready, 1);
    check("R1", "bus_valid", bus_valid, 0);
    check("R1", "nseq_next", nseq_next, 0);
    check("R1", "data_valid", data_valid, 0);
  endtask

  task automatic t_single_load;   run("R2", 1'b0, 1'b0, 1'b0, 5'd7, 32'h0000_1000, 32'h0000_8000, 1'b0); endtask
  task automatic t_single_store;  run("R3", 1'b1, 1'b0, 1'b1, 5'd3, 32'h0000_2004, 32'h0000_8010, 1'b0); endtask
  task automatic t_block_load;    run("R4", 1'b0, 1'b1, 1'b0, 5'd4, 32'h0000_3000, 32'h0000_9000, 1'b0); endtask
  task automatic t_block_one;     run("R4", 1'b0, 1'b1, 1'b0, 5'd1, 32'h0000_3100, 32'h0000_9100, 1'b0); endtask
  task automatic t_block_max;     run("R4", 1'b0, 1'b1, 1'b1, 5'd31, 32'h0000_4000, 32'h0000_9200, 1'b0); endtask
  task automatic t_desc_wrap;     run("R5", 1'b1, 1'b1, 1'b1, 5'd3, 32'h0000_0004, 32'h0000_9300, 1'b0); endtask
  task automatic t_asc_wrap;      run("R5", 1'b0, 1'b1, 1'b0, 5'd3, 32'hFFFF_FFF8, 32'h0000_9400, 1'b0); endtask
  task automatic t_count_zero;    run("R6", 1'b1, 1'b1, 1'b0, 5'd0, 32'h0000_5000, 32'h0000_9500, 1'b0); endtask
  task automatic t_busy_held;     run("R9", 1'b0, 1'b1, 1'b0, 5'd5, 32'h0000_6000, 32'h0000_9600, 1'b1); endtask
  task automatic t_store_block;   run("R10", 1'b1, 1'b1, 1'b0, 5'd2, 32'h0000_7000, 32'h0000_9700, 1'b0); endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single_load();
    t_single_store();
    t_block_load();
    t_block_one();
    t_block_max();
    t_desc_wrap();
    t_asc_wrap();
    t_count_zero();
    t_busy_held();
    t_store_block();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule